// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt requests from eight sources in a small 4-bit processor: two external pins, four timer underflows, an A-D completion and a serial-transfer completion. Each source has a sticky request flag. A request flag latches whenever its source fires, whether or not the source is enabled. Two 4-bit control registers hold one enable bit per source. A global enable flag is switched by set and clear commands from the core.

Each source's enable bit puts it in one of two modes. With the bit at 1 the source is vectored: when its flag is pending and global enable is on, the block takes the interrupt. Taking an interrupt picks the highest-priority pending source, pulses an acknowledge for one cycle with that source's vector address, clears that flag and turns global enable off. With the bit at 0 the source is polled: the core issues a skip query naming the source, and the block answers whether to skip. A successful skip consumes the flag.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset every request flag, every enable bit and the global enable are 0. `irq_ack` is 0, `irq_vec` is 0 and `skip_hit` is 0 for every `skip_sel`.
- R2: `irq_ack` is 1 exactly when the global enable is 1 and at least one source has both its request flag and its enable bit at 1. While `irq_ack` is 0, `irq_vec` is 0.
- R3: A `gie_set` pulse sets the global enable at the next edge. A `gie_clr` pulse clears it. Clear wins when both are given together. Taking an interrupt clears it at that edge even if `gie_set` is high, so `irq_ack` lasts one cycle.
- R4: A request flag stays set while it is masked by its enable bit or by the global enable. It stays set until it is cleared as R5 describes.
- R5: A take clears only the flag of the selected source. A skip query with `skip_hit` = 1 clears only the queried flag.
- R6: `skip_hit` = `skip_req` AND flag[`skip_sel`] AND NOT enable[`skip_sel`]. A source whose enable bit is 1 never skips.
- R7: Source index 0 = external 0, 1 = external 1, 2 to 5 = timers 1 to 4, 6 = A-D done, 7 = serial done. Among the pending enabled sources, the lowest index is taken.
- R8: `irq_vec` = 0x80 + 2 × index, which is page 1 of 128-word pages at word offsets 0x0 to 0xE.
- R9: A `ctl_wr` with `ctl_sel` = 0 loads `ctl_data[i]` into the enable bit of source i. With `ctl_sel` = 1 it loads the enable bit of source 4+i.
- R10: Any level change on `ext_pin[k]` sets flag k at the third rising edge after the change, through a two-flop synchronizer. A steady level sets nothing.
- R11: A one-cycle high on `tmr_uflow[j]`, `adc_done` or `sio_done` sets the flag of source 2+j, 6 or 7 at the next edge.
- R12: When a source event and a clear of the same flag fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ext_pin | input | 2 | External request pins, asynchronous |
| tmr_uflow | input | 4 | Timer 1..4 underflow pulses |
| adc_done | input | 1 | A-D completion pulse |
| sio_done | input | 1 | Serial transfer completion pulse |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_sel | input | 1 | Control register select |
| ctl_data | input | 4 | Enable bits to write |
| gie_set | input | 1 | Global enable set command |
| gie_clr | input | 1 | Global enable clear command |
| skip_req | input | 1 | Skip query strobe |
| skip_sel | input | 3 | Source index queried |
| skip_hit | output | 1 | Queried flag set in polled mode: skip |
| irq_ack | output | 1 | One-cycle interrupt take pulse |
| irq_vec | output | 8 | Vector address of the taken source |

## Verification
The first sweep covers all 256 patterns of pending flags with every source enabled. For each pattern it re-enables interrupts repeatedly until nothing remains. This separates a correct priority order from a reversed or partial one, and a one-flag clear from a clear of too many or too few flags. The second sweep covers all 256 enable patterns with every flag pending. It shows that the enable bits gate the pick, and that skip queries hit exactly the disabled sources. Directed cases pin down synchronizer and pulse latency, steady pins, set-over-clear collisions, and the precedence among the global-enable commands.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int IRQ_N      = 8;
    localparam int CTL_W      = 4;
    localparam int NUM_CTL    = IRQ_N / CTL_W;
    localparam int IDX_W      = $clog2(IRQ_N);
    localparam int CSEL_W     = (NUM_CTL > 1) ? $clog2(NUM_CTL) : 1;
    localparam int NUM_EXT    = 2;
    localparam int NUM_TMR    = 4;
    localparam int VEC_W      = 8;
    localparam int VEC_PAGE   = 1;
    localparam int PAGE_SHIFT = 7;

    function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
        return VEC_W'((VEC_PAGE << PAGE_SHIFT) + (int'(idx) << 1));
    endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] chg
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.s1 = pin;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    // a level difference between the last two synchronized samples is one change
    assign chg = sync_q.s2 ^ sync_q.s3;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        // scan from the top so the lowest set index is left last
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
    import irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EXT-1:0]  ext_pin,
    input  logic [NUM_TMR-1:0]  tmr_uflow,
    input  logic                adc_done,
    input  logic                sio_done,
    input  logic                ctl_wr,
    input  logic [CSEL_W-1:0]   ctl_sel,
    input  logic [CTL_W-1:0]    ctl_data,
    input  logic                gie_set,
    input  logic                gie_clr,
    input  logic                skip_req,
    input  logic [IDX_W-1:0]    skip_sel,
    output logic                skip_hit,
    output logic                irq_ack,
    output logic [VEC_W-1:0]    irq_vec
);
    typedef struct packed {
        logic [IRQ_N-1:0] flag;
        logic [IRQ_N-1:0] en;
        logic             gie;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [NUM_EXT-1:0] ext_chg;
    logic [IRQ_N-1:0]   evt_vec;
    logic [IRQ_N-1:0]   live;
    logic               pick_any;
    logic [IDX_W-1:0]   pick_idx;
    logic [IRQ_N-1:0]   ack_mask;
    logic [IRQ_N-1:0]   skip_mask;
    logic [IRQ_N-1:0]   clr_mask;

    irq_pin_sync #(.W(NUM_EXT)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .chg   (ext_chg)
    );

    assign evt_vec = {sio_done, adc_done, tmr_uflow, ext_chg};
    assign live    = st_q.flag & st_q.en;

    irq_prio_pick #(.N(IRQ_N), .IW(IDX_W)) u_pick (
        .req (live),
        .any (pick_any),
        .idx (pick_idx)
    );

    always_comb begin
        irq_ack   = st_q.gie & pick_any;
        irq_vec   = irq_ack ? vec_of(pick_idx) : '0;
        ack_mask  = irq_ack ? (IRQ_N'(1) << pick_idx) : '0;
        skip_hit  = skip_req & st_q.flag[skip_sel] & ~st_q.en[skip_sel];
        skip_mask = skip_hit ? (IRQ_N'(1) << skip_sel) : '0;
        clr_mask  = ack_mask | skip_mask;

        st_d = st_q;
        // an arriving event outranks any clear of the same flag
        st_d.flag = (st_q.flag & ~clr_mask) | evt_vec;
        for (int r = 0; r < NUM_CTL; r++) begin
            if (ctl_wr && ctl_sel == CSEL_W'(r)) st_d.en[r*CTL_W +: CTL_W] = ctl_data;
        end
        if (irq_ack || gie_clr) st_d.gie = 1'b0;
        else if (gie_set)       st_d.gie = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: the take turns the global enable off, so acknowledge never lasts two cycles
    a_r3_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> !irq_ack);

    // R2: no take while the global enable is off
    a_r2_masked_no_take: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.gie |-> !irq_ack);

    // R7: the picked source is live and nothing live sits below it
    a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (live[pick_idx] && ((live & ((IRQ_N'(1) << pick_idx) - IRQ_N'(1))) == '0)));

    // R4: no flag drops unless a take or a skip named it
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.flag) & ~$past(clr_mask) & ~st_q.flag) == '0));

    // R5: the taken flag is gone afterwards unless its source fired again
    a_r5_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> ((st_q.flag & $past(ack_mask) & ~$past(evt_vec)) == '0));

    // R12: every event leaves its flag set
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt_vec) & ~st_q.flag) == '0));

    // R6: an enabled source never answers a skip query
    a_r6_enabled_no_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_req && st_q.en[skip_sel]) |-> !skip_hit);
endmodule

// File: tb/tb_vec_irq_ctrl.sv
`timescale 1ns/1ps
module tb_vec_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_pin = '0;
    logic [3:0] tmr_uflow = '0;
    logic       adc_done = 1'b0, sio_done = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [0:0] ctl_sel = '0;
    logic [3:0] ctl_data = '0;
    logic       gie_set = 1'b0, gie_clr = 1'b0;
    logic       skip_req = 1'b0;
    logic [2:0] skip_sel = '0;
    logic       skip_hit, irq_ack;
    logic [7:0] irq_vec;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    vec_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_uflow(tmr_uflow),
        .adc_done(adc_done), .sio_done(sio_done), .ctl_wr(ctl_wr), .ctl_sel(ctl_sel),
        .ctl_data(ctl_data), .gie_set(gie_set), .gie_clr(gie_clr), .skip_req(skip_req),
        .skip_sel(skip_sel), .skip_hit(skip_hit), .irq_ack(irq_ack), .irq_vec(irq_vec)
    );

    task automatic chk(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic int vec_exp(input int idx);
        return 8'h80 + 2 * idx;
    endfunction

    function automatic int low_idx(input logic [7:0] m);
        for (int i = 7; i >= 0; i--) if (m[i]) low_idx = i;
        if (m == 0) low_idx = -1;
    endfunction

    // R9: register 0 carries sources 0..3, register 1 carries sources 4..7
    task automatic set_en(input logic [7:0] e);
        ctl_wr = 1'b1; ctl_sel = 1'b0; ctl_data = e[3:0]; step();
        ctl_sel = 1'b1; ctl_data = e[7:4]; step();
        ctl_wr = 1'b0;
    endtask

    // R10 and R11: toggle pins, pulse the rest, wait past the synchronizer
    task automatic raise(input logic [7:0] m);
        ext_pin = ext_pin ^ m[1:0];
        tmr_uflow = m[5:2]; adc_done = m[6]; sio_done = m[7];
        step();
        tmr_uflow = '0; adc_done = 1'b0; sio_done = 1'b0;
        repeat (3) step();
    endtask

    task automatic gie_on();
        gie_set = 1'b1; step(); gie_set = 1'b0; #1;
    endtask

    task automatic gie_off();
        gie_clr = 1'b1; step(); gie_clr = 1'b0;
    endtask

    task automatic skipq(input string rq, input int idx, input int exp);
        skip_req = 1'b1; skip_sel = 3'(idx); #1;
        chk(rq, int'(skip_hit), exp);
        step(); skip_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step(); #1;
        // R1 reset state
        chk("R1 ack", int'(irq_ack), 0);
        chk("R1 vec", int'(irq_vec), 0);
        for (int i = 0; i < 8; i++) skipq("R1 skip", i, 0);

        // R4 / R5: masked flag sticks, then one skip consumes it
        raise(8'h08);
        repeat (20) step();
        gie_on(); chk("R4 masked no ack", int'(irq_ack), 0); step(); gie_off();
        skipq("R4 sticky skip", 3, 1);
        skipq("R5 skip clears", 3, 0);

        // R10: exact synchronizer latency and steady level
        ext_pin[0] = 1'b1; step(); step();
        skipq("R10 not yet", 0, 0);
        skipq("R10 rise seen", 0, 1);
        repeat (5) step();
        skipq("R10 steady", 0, 0);
        ext_pin[0] = 1'b0; repeat (4) step();
        skipq("R10 fall seen", 0, 1);

        // R11: pulse latency
        tmr_uflow[2] = 1'b1;
        skipq("R11 not yet", 4, 0);
        tmr_uflow[2] = 1'b0;
        skipq("R11 pulse seen", 4, 1);

        // R12 skip collision: event and skip clear together
        raise(8'h40);
        skip_req = 1'b1; skip_sel = 3'd6; adc_done = 1'b1; #1;
        chk("R12 skip hit", int'(skip_hit), 1);
        step(); skip_req = 1'b0; adc_done = 1'b0;
        skipq("R12 flag kept after skip", 6, 1);

        // R12 take collision
        set_en(8'hFF);
        raise(8'h04);
        gie_on();
        chk("R12 ack", int'(irq_ack), 1);
        chk("R8 vec t1", int'(irq_vec), vec_exp(2));
        tmr_uflow[0] = 1'b1; step(); tmr_uflow[0] = 1'b0; #1;
        chk("R3 ack one cycle", int'(irq_ack), 0);
        gie_on();
        chk("R12 flag kept after take", int'(irq_vec), vec_exp(2));
        step();

        // R3: take beats a held set
        raise(8'h03);
        gie_set = 1'b1; step(); #1;
        chk("R3 ack", int'(irq_ack), 1);
        chk("R7 ext0 first", int'(irq_vec), vec_exp(0));
        step(); gie_set = 1'b0; #1;
        chk("R3 take beats set", int'(irq_ack), 0);
        gie_on();
        chk("R7 ext1 next", int'(irq_vec), vec_exp(1));
        step();

        // R3: clear command, and clear winning over set
        gie_on(); gie_off();
        raise(8'h20); #1;
        chk("R3 cleared no ack", int'(irq_ack), 0);
        gie_set = 1'b1; gie_clr = 1'b1; step(); gie_set = 1'b0; gie_clr = 1'b0; #1;
        chk("R3 clr beats set", int'(irq_ack), 0);
        gie_on();
        chk("R8 vec t4", int'(irq_vec), vec_exp(5));
        step();

        // Sweep A: every pending pattern, all enabled (R2 R5 R7 R8)
        for (int m = 0; m < 256; m++) begin
            logic [7:0] rem;
            rem = 8'(m);
            raise(rem);
            while (rem != 0) begin
                int k;
                k = low_idx(rem);
                gie_on();
                chk("R2 ack pending", int'(irq_ack), 1);
                chk("R7 R8 vec order", int'(irq_vec), vec_exp(k));
                rem[k] = 1'b0;
                step(); #1;
                chk("R3 single", int'(irq_ack), 0);
            end
            gie_on();
            chk("R5 all drained", int'(irq_ack), 0);
            chk("R2 vec idle", int'(irq_vec), 0);
            step(); gie_off();
        end

        // Sweep B: every enable pattern, all pending (R9 R6 R2)
        for (int e = 0; e < 256; e++) begin
            set_en(8'(e));
            raise(8'hFF);
            gie_on();
            chk("R9 ack gated", int'(irq_ack), (e != 0) ? 1 : 0);
            if (e != 0) chk("R9 vec gated", int'(irq_vec), vec_exp(low_idx(8'(e))));
            step(); gie_off();
            for (int i = 0; i < 8; i++) skipq("R6 skip mode", i, e[i] ? 0 : 1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule